// File: doc/BRIEF.md
# SPI Transfer Status and Error Flag Controller

This block holds the status flags and the receive holding buffer of a byte-wide serial peripheral that a CPU drives through three registers: control, status and data. A separate shift engine reports each finished byte with a one-cycle pulse and the byte it collected. It also reports whether a transfer is in progress and whether another master has pulled the select line. From these inputs and the CPU read and write strobes, the block keeps four flags: byte complete, overrun, write collision and mode fault. It decides which received byte stays in the holding buffer and passes an accepted transmit byte to the shift engine. It also raises the interrupt request.

Every flag is cleared by a sequence of register accesses, and there is no write-one-to-clear. Byte complete is cleared by a status read that sees it set, followed by a data read. Write collision is cleared by a status read that sees it set, followed by any data access. Overrun is cleared by a status read. Mode fault is cleared by a status read that sees it set, followed by a control write. While a mode fault is pending, the enable and master bits cannot be set again, except by the control write that ends the clearing sequence. On an overrun the buffer keeps the first unread byte, and every byte that arrives after it is discarded.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After reset all four flags, all three control bits, the holding buffer and `irq` are 0.
- R2: A `shift_done` pulse sets the byte-complete flag (status bit 0). A status read that sees it set, followed by a data read, clears it. If a new `shift_done` falls in the clearing cycle, the flag stays set.
- R3: A `shift_done` that arrives while byte complete is set, and not cleared in that same cycle, sets overrun and leaves the holding buffer unchanged. Any other `shift_done` loads `shift_rx` into the buffer, and a data read returns the buffer.
- R4: Overrun (status bit 1) is cleared by any status read. If a new overrun condition falls in that cycle, the flag stays set.
- R5: A data write while `busy` is high leaves `tx_load` low and sets write collision (status bit 2). A data write while `busy` is low pulses `tx_load`, with `tx_data` equal to the written byte.
- R6: Write collision is cleared by a status read that sees it set, followed by a data read or data write. A new collision in that cycle keeps the flag set. Collisions are flagged in both master and slave modes.
- R7: `irq` equals interrupt-enable AND (byte complete OR overrun OR mode fault). Write collision never raises `irq`.
- R8: `fault_det` while the master bit is set sets mode fault (status bit 3) and clears the enable and master bits.
- R9: `fault_det` while the master bit is clear has no effect on mode fault.
- R10: While mode fault is set and not armed, a control write can clear the enable and master bits but cannot set them. A status read that sees mode fault arms the clear, and the next control write then clears mode fault and writes all control bits.
- R11: The register select `cpu_sel` uses 0 for control, 1 for status and 2 for data. Control bit 0 is enable, bit 1 is master and bit 2 is interrupt enable. Interrupt enable can always be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wr | input | 1 | Register write strobe |
| cpu_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data of the selected register |
| shift_done | input | 1 | One-cycle pulse: a byte finished shifting |
| shift_rx | input | DATA_W | Byte received by the shift engine |
| busy | input | 1 | A transfer is in progress |
| fault_det | input | 1 | Another master drove the select line |
| tx_load | output | 1 | Accepted transmit byte strobe |
| tx_data | output | DATA_W | Transmit byte |
| spi_en | output | 1 | Enable control bit |
| spi_master | output | 1 | Master control bit |
| spi_ie | output | 1 | Interrupt enable control bit |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can fall in the same cycle here, and each pair is driven on purpose. In the first pair, a byte completes in the very cycle that a data read finishes clearing the byte-complete flag. The bench expects the flag to stay set, no overrun to be raised and the new byte to enter the buffer. In the second pair, a data write arrives while the engine is busy, in the same cycle that it completes a write-collision clear. The bench expects the collision flag to stay set and no byte to be loaded. A behavioural model in the bench predicts every flag, control bit and output in each cycle and compares them all.

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_sel,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              shift_done,
  input  logic [DATA_W-1:0] shift_rx,
  input  logic              busy,
  input  logic              fault_det,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_data,
  output logic              spi_en,
  output logic              spi_master,
  output logic              spi_ie,
  output logic              irq
);
  localparam logic [1:0] SEL_CTRL = 2'd0, SEL_STAT = 2'd1, SEL_DATA = 2'd2;

  logic [DATA_W-1:0] rbuf;
  logic done_f, ovr_f, coll_f, fault_f;
  logic done_arm, coll_arm, fault_arm;

  wire stat_rd  = cpu_rd && cpu_sel == SEL_STAT;
  wire data_rd  = cpu_rd && cpu_sel == SEL_DATA;
  wire data_wr  = cpu_wr && cpu_sel == SEL_DATA;
  wire ctrl_wr  = cpu_wr && cpu_sel == SEL_CTRL;
  wire done_clr = data_rd && done_arm;
  wire ovr_hit  = shift_done && done_f && !done_clr;
  wire coll_hit = data_wr && busy;
  wire coll_clr = (data_rd || data_wr) && coll_arm;
  wire fault_hit = fault_det && spi_master;

  assign tx_load = data_wr && !busy;
  assign tx_data = cpu_wdata;
  assign irq     = spi_ie && (done_f || ovr_f || fault_f);

  always_comb begin
    cpu_rdata = '0;
    case (cpu_sel)
      SEL_CTRL: cpu_rdata[2:0] = {spi_ie, spi_master, spi_en};
      SEL_STAT: cpu_rdata[3:0] = {fault_f, coll_f, ovr_f, done_f};
      SEL_DATA: cpu_rdata = rbuf;
      default:  cpu_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbuf <= '0;
      done_f <= 1'b0; ovr_f <= 1'b0; coll_f <= 1'b0; fault_f <= 1'b0;
      done_arm <= 1'b0; coll_arm <= 1'b0; fault_arm <= 1'b0;
      spi_en <= 1'b0; spi_master <= 1'b0; spi_ie <= 1'b0;
    end else begin
      if (shift_done && !ovr_hit) rbuf <= shift_rx;

      if (shift_done)    done_f <= 1'b1;
      else if (done_clr) done_f <= 1'b0;
      if (stat_rd)       done_arm <= done_f;
      else if (data_rd)  done_arm <= 1'b0;

      if (ovr_hit)       ovr_f <= 1'b1;
      else if (stat_rd)  ovr_f <= 1'b0;

      if (coll_hit)      coll_f <= 1'b1;
      else if (coll_clr) coll_f <= 1'b0;
      if (stat_rd)                  coll_arm <= coll_f;
      else if (data_rd || data_wr)  coll_arm <= 1'b0;

      if (ctrl_wr) spi_ie <= cpu_wdata[2];

      if (fault_hit) begin
        fault_f <= 1'b1;
        fault_arm <= 1'b0;
        spi_en <= 1'b0;
        spi_master <= 1'b0;
      end else begin
        if (stat_rd)      fault_arm <= fault_f;
        else if (ctrl_wr) fault_arm <= 1'b0;
        if (ctrl_wr) begin
          if (fault_f && !fault_arm) begin
            spi_en     <= spi_en && cpu_wdata[0];
            spi_master <= spi_master && cpu_wdata[1];
          end else begin
            spi_en     <= cpu_wdata[0];
            spi_master <= cpu_wdata[1];
          end
          if (fault_arm) fault_f <= 1'b0;
        end
      end
    end
  end

  assert_done_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_done |=> done_f);
  assert_ovr_keeps_buf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_done && done_f && !data_rd) |=> (ovr_f && $stable(rbuf)));
  assert_coll_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy) |=> coll_f);
  assert_irq_no_coll_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_f && !ovr_f && !fault_f) |-> !irq);
  assert_fault_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_det && spi_master) |=> (fault_f && !spi_en && !spi_master));
  assert_slave_no_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_f && !(fault_det && spi_master)) |=> !fault_f);
  assert_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_f && !fault_arm && ctrl_wr) |=> ((!spi_en || $past(spi_en)) && (!spi_master || $past(spi_master))));
endmodule

// File: tb/spi_flag_ctrl_bench.sv
module spi_flag_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_rd = 0, cpu_wr = 0, shift_done = 0, busy = 0, fault_det = 0;
  logic [1:0] cpu_sel = 0;
  logic [DW-1:0] cpu_wdata = 0, shift_rx = 0;
  logic [DW-1:0] cpu_rdata, tx_data;
  logic tx_load, spi_en, spi_master, spi_ie, irq;

  int total = 0, bad = 0;
  bit finished = 0;

  // behavioural reference state
  int m_buf;
  bit m_done, m_ovr, m_coll, m_fault, m_darm, m_carm, m_farm, m_en, m_ms, m_ie;

  spi_flag_ctrl #(.DATA_W(DW)) u_spi_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .shift_done(shift_done),
    .shift_rx(shift_rx), .busy(busy), .fault_det(fault_det), .tx_load(tx_load),
    .tx_data(tx_data), .spi_en(spi_en), .spi_master(spi_master), .spi_ie(spi_ie),
    .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_buf = 0; m_done = 0; m_ovr = 0; m_coll = 0; m_fault = 0;
    m_darm = 0; m_carm = 0; m_farm = 0; m_en = 0; m_ms = 0; m_ie = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit srd, drd, dwr, cwr, dclr, ovh, flt;
      srd = cpu_rd && cpu_sel == 1; drd = cpu_rd && cpu_sel == 2;
      dwr = cpu_wr && cpu_sel == 2; cwr = cpu_wr && cpu_sel == 0;
      dclr = drd && m_darm;
      ovh = shift_done && m_done && !dclr;
      flt = fault_det && m_ms;
      if (shift_done && !ovh) m_buf = shift_rx;
      if (ovh) m_ovr = 1; else if (srd) m_ovr = 0;
      if (dwr && busy) m_coll = 1; else if ((drd || dwr) && m_carm) m_coll = 0;
      if (shift_done) m_done = 1; else if (dclr) m_done = 0;
      if (srd) begin m_darm = m_done; m_carm = m_coll; end
      if (drd) m_darm = 0;
      if (drd || dwr) m_carm = 0;
      if (cwr) m_ie = cpu_wdata[2];
      if (flt) begin
        m_fault = 1; m_farm = 0; m_en = 0; m_ms = 0;
      end else if (cwr) begin
        if (m_fault && !m_farm) begin
          m_en = m_en & cpu_wdata[0]; m_ms = m_ms & cpu_wdata[1];
        end else begin
          m_en = cpu_wdata[0]; m_ms = cpu_wdata[1];
        end
        if (m_farm) m_fault = 0;
        m_farm = 0;
      end else if (srd) m_farm = m_fault;
    end
  end

  task automatic compare();
    chk("R5 tx_load", tx_load, (cpu_wr && cpu_sel == 2 && !busy));
    if (cpu_wr && cpu_sel == 2 && !busy) chk("R5 tx_data", tx_data, cpu_wdata);
    chk("R7 irq", irq, m_ie && (m_done || m_ovr || m_fault));
    chk("R10 enable", spi_en, m_en);
    chk("R10 master", spi_master, m_ms);
    chk("R11 ie", spi_ie, m_ie);
    case (cpu_sel)
      2'd0: chk("R11 control read", cpu_rdata, {m_ie, m_ms, m_en});
      2'd1: begin
        chk("R2 complete flag", cpu_rdata[0], m_done);
        chk("R4 overrun flag", cpu_rdata[1], m_ovr);
        chk("R6 collision flag", cpu_rdata[2], m_coll);
        chk("R8 fault flag", cpu_rdata[3], m_fault);
      end
      2'd2: chk("R3 buffer", cpu_rdata, m_buf);
      default: ;
    endcase
  endtask

  // one cycle of stimulus: drive after negedge, compare, let posedge pass
  task automatic cyc(input bit rd, input bit wr, input int sel, input int wd,
                     input bit sd, input int rx, input bit bsy, input bit flt);
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_sel = sel[1:0]; cpu_wdata = wd[DW-1:0];
    shift_done = sd; shift_rx = rx[DW-1:0]; busy = bsy; fault_det = flt;
    #1 compare();
  endtask

  task automatic idle();            cyc(0,0,1,0,0,0,0,0); endtask
  task automatic rd_reg(int s);     cyc(1,0,s,0,0,0,0,0); endtask
  task automatic wr_reg(int s, int d); cyc(0,1,s,d,0,0,0,0); endtask
  task automatic shift(int b);      cyc(0,0,2,0,1,b,1,0); endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    cpu_sel = 1; #1 chk("R1 status after reset", cpu_rdata, 0);
    cpu_sel = 2; #1 chk("R1 buffer after reset", cpu_rdata, 0);
    chk("R1 irq after reset", irq, 0);
    chk("R1 controls after reset", {spi_ie, spi_master, spi_en}, 0);
    rst_n = 1;

    wr_reg(0, 7);
    shift(8'hA5); idle();
    rd_reg(1); rd_reg(2); idle();
    chk("R2 cleared by sequence", m_done, 0);

    // overrun: first unread byte kept
    shift(8'h11); shift(8'h22); shift(8'h33); idle();
    rd_reg(1); rd_reg(2); idle();
    chk("R3 first byte kept", m_buf, 8'h11);
    // clearing read coincides with new byte: set wins, no overrun
    shift(8'h44); rd_reg(1);
    cyc(1,0,2,0,1,8'h55,1,0); idle(); rd_reg(2);
    // data read without prior status read leaves flag
    shift(8'h66); rd_reg(2); idle();
    rd_reg(1); rd_reg(2); idle();

    // write collision and load
    cyc(0,1,2,8'h9C,0,0,1,0); idle();
    cyc(0,1,2,8'h3E,0,0,0,0); idle();
    rd_reg(1);
    cyc(0,1,2,8'h77,0,0,1,0); idle();   // clear and new collision same cycle
    rd_reg(1); cyc(0,1,2,8'h5A,0,0,0,0); idle();
    rd_reg(1); cyc(1,0,2,0,0,0,0,0); idle();

    // mode fault in master
    wr_reg(0, 3); cyc(0,0,1,0,0,0,0,1); idle();
    wr_reg(0, 7); idle();               // locked
    wr_reg(0, 0); idle();
    rd_reg(1); wr_reg(0, 7); idle();    // clears fault, restores bits
    chk("R10 restored enable", spi_en, 1);

    // slave: fault ignored, collision still flagged
    wr_reg(0, 5); cyc(0,0,1,0,0,0,0,1); idle();
    chk("R9 no fault in slave", cpu_rdata[3], 0);
    cyc(0,1,2,8'h12,0,0,1,0); idle();
    rd_reg(1); rd_reg(2); idle();
    wr_reg(0, 0); shift(8'hE1); idle();
    chk("R7 irq masked", irq, 0);

    repeat (4) idle();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule